// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block connects a processor-side request port to a 16-bit memory made of two byte-wide banks. The processor asks for a byte or a word, read or write, at a 20-bit byte address. The block picks the bank or banks to enable and moves each byte onto the data lane its bank uses. Even-addressed bytes sit in the low bank on bits 7..0. Odd-addressed bytes sit in the high bank on bits 15..8.

A byte at either parity, or a word starting at an even address, takes one memory transaction. A word starting at an odd address takes two byte transactions: first the odd byte at X on the high lane, then the even byte at X+1 on the low lane. Read results are put back together with the byte from X as the low half. Write data is split the same way in the opposite direction. The address of the second transaction wraps within the 20-bit space.

The processor side uses a valid/ready handshake. Ready is low while a request is in progress. A read returns its data with a one-cycle response pulse. On the memory side the block holds a request level with a stable address and enables. The memory ends each transaction with a one-cycle done strobe.

Top module: `lane_splitter`

## Requirements
- R1: During reset and straight after it, reqReady is 1, memReq is 0 and rspValid is 0.
- R2: A byte access at an even address X uses one transaction at X with memAddr[0]=0 and memHiEnN=1 (enable pair {memAddr[0],memHiEnN} = 01). A write puts reqWdata[7:0] on memWdata[7:0]. A read returns {8'h00, memRdata[7:0]}.
- R3: A byte access at an odd address X uses one transaction at X with pair 10. A write puts reqWdata[7:0] on memWdata[15:8]. A read returns {8'h00, memRdata[15:8]}.
- R4: A word access at an even address X uses one transaction at X with pair 00 and the full 16-bit bus, with the byte at X on bits 7..0.
- R5: A word access at an odd address X uses exactly two transactions. The first is at X with pair 10. The second starts only after the first one's memDone and is at X+1 with pair 01.
- R6: For a split read, result bits 7..0 are memRdata[15:8] from the first transaction and bits 15..8 are memRdata[7:0] from the second.
- R7: For a split write, reqWdata[7:0] goes out on the high lane in the first transaction and reqWdata[15:8] on the low lane in the second.
- R8: A word access at 20'hFFFFF makes its second transaction at address 20'h00000.
- R9: reqReady drops in the cycle after a request is accepted and stays low until the cycle after the final memDone. reqValid is ignored while reqReady is low.
- R10: rspValid is a single-cycle pulse in the cycle after the final memDone of a read. It goes high together with the return of reqReady. A write gives no pulse.
- R11: While memReq is high and memDone has not arrived, memAddr and memHiEnN hold steady.
- R12: During any transaction at least one bank is enabled. The pair 11 never appears while memReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqAddr | input | 20 | Byte address of the access (lowest byte of a word) |
| reqWdata | input | 16 | Write data; a byte uses bits 7..0 |
| rspValid | output | 1 | One-cycle read-result pulse |
| rspData | output | 16 | Read result, byte results zero-extended |
| memReq | output | 1 | Memory transaction active |
| memWrite | output | 1 | Transaction is a write |
| memAddr | output | 20 | Bits 19..1 pick the location in each bank; bit 0 low enables the low bank |
| memHiEnN | output | 1 | Active-low high-bank enable |
| memWdata | output | 16 | Write data lanes |
| memRdata | input | 16 | Read data lanes, sampled with memDone |
| memDone | input | 1 | Ends the current transaction |

## Verification
The bench builds the block with its default widths: a 20-bit address and a 16-bit bus. These widths make the top address 20'hFFFFF reachable, so the wrap of a split word's second transaction to address zero can be exercised directly. The memory model answers with a latency of zero to two cycles. This covers the case where the second half of a split starts straight after the first half's done strobe, and the case where the enables must stay steady across several waiting cycles. Reads placed after writes show through the normal read path that every byte lane landed at the right address.

// File: rtl/lane_splitter_pkg.sv
package lane_splitter_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // latch an accepted request
    logic inSecond;  // second half of a split word is on the bus
    logic takeLow;   // keep the high-lane byte of the first half
    logic finish;    // final transaction completed this cycle
  } strobe_t;
endpackage

// File: rtl/lane_splitter_ctrl.sv
module lane_splitter_ctrl
  import lane_splitter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memDone,
  input  logic    needSplit,
  output logic    reqReady,
  output logic    memReq,
  output strobe_t strobe
);
  typedef enum logic [1:0] {IDLE, FIRST, SECOND} state_t;
  state_t state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          nextState   = FIRST;
        end
      end
      FIRST: begin
        if (memDone) begin
          if (needSplit) begin
            strobe.takeLow = 1'b1;
            nextState      = SECOND;
          end else begin
            strobe.finish = 1'b1;
            nextState     = IDLE;
          end
        end
      end
      SECOND: begin
        strobe.inSecond = 1'b1;
        if (memDone) begin
          strobe.finish = 1'b1;
          nextState     = IDLE;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == IDLE);
  assign memReq   = (state != IDLE);
endmodule

// File: rtl/lane_splitter_dp.sv
module lane_splitter_dp
  import lane_splitter_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              memReq,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              needSplit,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memHiEnN,
  output logic [DATA_W-1:0] memWdata
);
  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic              isWord, isWrite, fullWord;
  logic [LANE_W-1:0] lowByte, sendByte;
  logic [DATA_W-1:0] readResult;

  assign needSplit = isWord & addrReg[0];
  assign fullWord  = isWord & ~addrReg[0];

  // second half of a split word sits one byte above, wrapping at the top
  assign memAddr  = strobe.inSecond ? addrReg + ADDR_W'(1) : addrReg;
  assign memHiEnN = ~(memReq & (memAddr[0] | fullWord));
  assign memWrite = memReq & isWrite;

  // write lanes: single bytes are copied onto both lanes, the enables pick one
  assign sendByte = strobe.inSecond ? wdataReg[DATA_W-1:LANE_W] : wdataReg[LANE_W-1:0];
  assign memWdata = fullWord ? wdataReg : {sendByte, sendByte};

  always_comb begin
    if (fullWord)
      readResult = memRdata;
    else if (strobe.inSecond)
      readResult = {memRdata[LANE_W-1:0], lowByte};
    else if (addrReg[0])
      readResult = {{LANE_W{1'b0}}, memRdata[DATA_W-1:LANE_W]};
    else
      readResult = {{LANE_W{1'b0}}, memRdata[LANE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      isWord   <= 1'b0;
      isWrite  <= 1'b0;
      lowByte  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
        isWord   <= reqWord;
        isWrite  <= reqWrite;
      end
      if (strobe.takeLow) lowByte <= memRdata[DATA_W-1:LANE_W];
      rspValid <= strobe.finish & ~isWrite;
      if (strobe.finish & ~isWrite) rspData <= readResult;
    end
  end
endmodule

// File: rtl/lane_splitter.sv
module lane_splitter
  import lane_splitter_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memHiEnN,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);
  strobe_t strobe;
  logic    needSplit;

  lane_splitter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memDone(memDone),
    .needSplit(needSplit), .reqReady(reqReady), .memReq(memReq), .strobe(strobe)
  );

  lane_splitter_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memReq(memReq),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memRdata(memRdata), .needSplit(needSplit), .rspValid(rspValid), .rspData(rspData),
    .memWrite(memWrite), .memAddr(memAddr), .memHiEnN(memHiEnN), .memWdata(memWdata)
  );
endmodule

// File: rtl/lane_splitter_chk.sv
module lane_splitter_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memHiEnN,
  input logic              memDone
);
  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memDone |=> memReq && $stable(memAddr) && $stable(memHiEnN));

  // R12
  bank_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !(memAddr[0] && memHiEnN));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R10
  rsp_with_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> reqReady && !memReq);
endmodule

bind lane_splitter lane_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memReq(memReq), .memAddr(memAddr),
  .memHiEnN(memHiEnN), .memDone(memDone)
);

// File: tb/lane_splitter_tb.sv
module lane_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [1:0]    pair;
  } tx_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspValid, memReq, memWrite, memHiEnN;
  logic [DW-1:0] rspData, memWdata;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdata = '0;
  logic          memDone = 1'b0;

  int nChecks = 0, nErr = 0, memLat = 0;
  bit finished = 0;
  tx_t           txQ[$];
  logic [DW-1:0] rspQ[$];
  string         rspTag[$];
  string         txTag[$];
  logic [7:0]    devMem[int];
  logic [7:0]    refMem[int];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_splitter u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memReq(memReq), .memWrite(memWrite),
    .memAddr(memAddr), .memHiEnN(memHiEnN), .memWdata(memWdata),
    .memRdata(memRdata), .memDone(memDone)
  );

  function automatic logic [7:0] seedByte(int a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] rdDev(int a);
    return devMem.exists(a) ? devMem[a] : seedByte(a);
  endfunction
  function automatic logic [7:0] rdRef(int a);
    return refMem.exists(a) ? refMem[a] : seedByte(a);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  endtask

  // memory model: compares each transaction with the scoreboard and answers it
  bit            busy = 0;
  int            latLeft = 0;
  logic [AW-1:0] startAddr;
  logic          startHi;
  always @(negedge clk) begin
    if (!rstN) begin
      memDone = 1'b0;
      busy = 0;
    end else if (memDone) begin
      memDone = 1'b0;
      busy = 0;
    end else if (memReq) begin
      if (!busy) begin
        busy = 1;
        latLeft = memLat;
        startAddr = memAddr;
        startHi = memHiEnN;
        if (txQ.size() == 0) begin
          check(32'({memAddr, memAddr[0], memHiEnN}), 32'hFFFFFFFF, "R9", "unexpected transaction");
        end else begin
          tx_t e;
          string t;
          e = txQ.pop_front();
          t = txTag.pop_front();
          check(32'(memAddr), 32'(e.addr), t, "transaction address");
          check(32'({memAddr[0], memHiEnN}), 32'(e.pair), {t, " R12"}, "enable pair");
        end
      end
      if (latLeft == 0) begin
        int a;
        check(32'({startAddr, startHi}), 32'({memAddr, memHiEnN}), "R11", "held address/enable");
        a = int'({memAddr[AW-1:1], 1'b0});
        memRdata = {rdDev(a + 1), rdDev(a)};
        if (memWrite) begin
          if (!memAddr[0]) devMem[a] = memWdata[7:0];
          if (!memHiEnN) devMem[a + 1] = memWdata[15:8];
        end
        memDone = 1'b1;
      end else begin
        latLeft--;
      end
    end
  end

  // response monitor: pops the scoreboard on every pulse
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      check(32'(reqReady), 32'd1, "R10", "ready with response");
      if (rspQ.size() == 0) begin
        check(32'(rspData), 32'hFFFFFFFF, "R10", "response with none pending");
      end else begin
        logic [DW-1:0] e;
        string t;
        e = rspQ.pop_front();
        t = rspTag.pop_front();
        check(32'(rspData), 32'(e), t, "read data");
      end
    end
  end

  task automatic doReq(bit wr, bit wd, int unsigned addr, logic [DW-1:0] data, int lat, string tag);
    logic [AW-1:0] x, y;
    x = AW'(addr);
    y = x + AW'(1);
    memLat = lat;
    if (wd && x[0]) begin
      txQ.push_back('{x, 2'b10}); txTag.push_back(tag);
      txQ.push_back('{y, 2'b01}); txTag.push_back(tag);
    end else if (wd) begin
      txQ.push_back('{x, 2'b00}); txTag.push_back(tag);
    end else begin
      txQ.push_back('{x, x[0] ? 2'b10 : 2'b01}); txTag.push_back(tag);
    end
    if (wr) begin
      refMem[int'(x)] = data[7:0];
      if (wd) refMem[int'(y)] = data[15:8];
    end else begin
      rspQ.push_back(wd ? {rdRef(int'(y)), rdRef(int'(x))} : {8'h00, rdRef(int'(x))});
      rspTag.push_back(tag);
    end
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = wd; reqAddr = x; reqWdata = data;
    @(negedge clk);
    check(32'(reqReady), 32'd0, "R9", "ready after accept");
    // junk held on the port while busy must be ignored
    reqAddr = ~x; reqWrite = ~wr; reqWdata = ~data;
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqReady) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(32'({reqReady, memReq, rspValid}), 32'b100, "R1", "reset outputs");
    rstN = 1'b1;
    @(negedge clk);
    check(32'({reqReady, memReq, rspValid}), 32'b100, "R1", "after reset");

    doReq(0, 0, 20'h00124, 16'h0, 0, "R2");
    doReq(0, 0, 20'h00125, 16'h0, 1, "R3");
    doReq(0, 1, 20'h00200, 16'h0, 2, "R4");
    doReq(0, 1, 20'h0072B, 16'h0, 0, "R5 R6");
    doReq(0, 1, 20'h0072B, 16'h0, 2, "R6");
    doReq(1, 0, 20'h00300, 16'h77A5, 1, "R2");
    doReq(1, 0, 20'h00301, 16'h883C, 0, "R3");
    doReq(0, 1, 20'h00300, 16'h0, 0, "R2 R3");
    doReq(1, 1, 20'h00400, 16'hBEEF, 2, "R4");
    doReq(0, 1, 20'h00400, 16'h0, 0, "R4");
    doReq(1, 1, 20'h00009, 16'h55FF, 1, "R7");
    doReq(0, 1, 20'h00008, 16'h0, 0, "R7");
    doReq(0, 1, 20'h0000A, 16'h0, 1, "R7");
    doReq(0, 1, 20'hFFFFF, 16'h0, 0, "R8");
    doReq(1, 1, 20'hFFFFF, 16'h1234, 2, "R8");
    doReq(0, 0, 20'h00000, 16'h0, 0, "R8");
    doReq(0, 0, 20'hFFFFF, 16'h0, 1, "R8");
    doReq(1, 0, 20'h00500, 16'h0011, 0, "R10");

    repeat (5) @(negedge clk);
    check(32'(txQ.size()), 32'd0, "R5", "transactions left over");
    check(32'(rspQ.size()), 32'd0, "R10", "responses left over");
    finishRun();
  end
endmodule